// File: doc/BRIEF.md
# Extended-Precision to Integer Store Converter

This block turns an 80-bit extended-precision floating-point operand into a signed integer of 16, 32 or 64 bits, ready to be written to memory by an integer-store path. The fractional part is discarded, so the result is truncated toward zero. The operand has a sign bit, a 15-bit biased exponent with bias 16383, and a 64-bit significand whose top bit is an explicit integer bit. The integer is presented on a 64-bit bus. Bits above the selected width are zero.

Three kinds of input cannot be stored: a NaN, an infinity, and a value whose truncated magnitude does not fit in the signed range of the selected width. Each of these raises an invalid flag. If the invalid exception is masked, the block substitutes the integer indefinite pattern and still requests the store. That pattern is the sign bit of the selected width set with every other bit clear. If the exception is unmasked, the flag is raised and no store is requested. A correctly converted most-negative integer has the same bit pattern as the indefinite value, but its flag is clear. Downstream logic uses the flag to tell the two apart.

Each accepted operand produces one result, registered one clock cycle later.

Top module: `ext_int_store`

## Requirements
- R1: A result appears on `out_valid` exactly one clock cycle after `in_valid` is sampled high. Otherwise `out_valid` is low, and it is low after reset.
- R2: The width code selects the integer size: 2'b00 selects 16 bits, 2'b01 selects 32 bits, and 2'b10 or 2'b11 selects 64 bits. Bits of `out_data` above the selected width are zero.
- R3: An in-range value converts with truncation toward zero. For example, +2.75 gives 2 and -2.75 gives -2.
- R4: A negative result is the two's complement of the truncated magnitude, taken at the selected width.
- R5: An operand whose exponent field is all ones (a NaN or an infinity) is an invalid operation.
- R6: The operation is invalid when the truncated magnitude is out of range. For a positive sign that means above 2^(W-1)-1. For a negative sign that means above 2^(W-1). This covers an exponent above 16446 with a nonzero significand.
- R7: On an invalid operation with the mask bit at 1, `out_data` holds the indefinite pattern (bit W-1 set, all other bits zero), `out_invalid` is 1 and `out_store_en` is 1.
- R8: On an invalid operation with the mask bit at 0, `out_invalid` is 1, `out_store_en` is 0 and `out_data` is zero.
- R9: A value whose truncated result is exactly -2^(W-1) converts to the same pattern as the indefinite value, with `out_invalid` at 0 and `out_store_en` at 1.
- R10: Zero, and any value of magnitude below one of either sign, converts to 0 with `out_invalid` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| in_operand | input | 80 | Extended-precision operand: sign[79], exponent[78:64], significand[63:0] |
| in_width | input | 2 | Integer size code (00: 16, 01: 32, 1x: 64) |
| in_inv_mask | input | 1 | 1 masks the invalid exception (indefinite is stored) |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Integer result, zero-extended above the selected width |
| out_store_en | output | 1 | Store request for the result |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
The bench builds the block with its default parameters: a 15-bit exponent, a 64-bit significand and three widths starting at 16 bits. With these values every boundary is exercised at its real size. That includes the 2^15, 2^31 and 2^63 limits on both sides of zero, and the exponent 16446 at which the significand's integer bit lands on bit 0. The bench builds its operands by normalising integers it chooses itself, so a one-off error in the shift distance or the range limit shows up as a wrong value or a wrong flag at those limits.

// File: rtl/ext_int_pkg.sv
package ext_int_pkg;

   // Integer size select codes; the top code aliases the widest size.
   typedef enum logic [1:0] {
      IW_NARROW = 2'b00,
      IW_MID    = 2'b01,
      IW_WIDE   = 2'b10,
      IW_WIDE_B = 2'b11
   } int_width_e;

   // Map a size code to a width index, clamping to the widest entry.
   function automatic int unsigned width_index(input logic [1:0] code, input int unsigned n_widths);
      int unsigned c;
      c = int'(code);
      return (c >= n_widths - 1) ? n_widths - 1 : c;
   endfunction

endpackage

// File: rtl/ext_field_split.sv
module ext_field_split #(
   parameter int EXP_W = 15,
   parameter int SIG_W = 64,
   localparam int OP_W = 1 + EXP_W + SIG_W
) (
   input  logic [OP_W-1:0]  operand,
   output logic             sign,
   output logic [EXP_W-1:0] exponent,
   output logic [SIG_W-1:0] significand,
   output logic             special
);

   if (EXP_W < 2) begin : g_bad_exp
      $error("ext_field_split: EXP_W too small");
   end

   always_comb begin
      sign        = operand[OP_W-1];
      exponent    = operand[OP_W-2 -: EXP_W];
      significand = operand[SIG_W-1:0];
      // All-ones exponent: NaN or infinity of any form.
      special     = &exponent;
   end

endmodule

// File: rtl/ext_mag_shift.sv
module ext_mag_shift #(
   parameter int EXP_W = 15,
   parameter int SIG_W = 64,
   localparam int BIAS    = (1 << (EXP_W - 1)) - 1,
   localparam int INT_TOP = BIAS + SIG_W - 1
) (
   input  logic [EXP_W-1:0] exponent,
   input  logic [SIG_W-1:0] significand,
   output logic [SIG_W-1:0] magnitude,
   output logic             too_big
);

   localparam int SH_W = EXP_W + 1;

   if (INT_TOP >= (1 << EXP_W)) begin : g_bad_top
      $error("ext_mag_shift: integer point beyond exponent range");
   end

   logic [SH_W-1:0] shamt;
   logic            above_top;

   always_comb begin
      above_top = {1'b0, exponent} > SH_W'(INT_TOP);
      shamt     = SH_W'(INT_TOP) - {1'b0, exponent};
      if (above_top) begin
         magnitude = '0;
         too_big   = |significand;
      end else begin
         magnitude = significand >> shamt;
         too_big   = 1'b0;
      end
   end

endmodule

// File: rtl/int_range_fit.sv
module int_range_fit #(
   parameter int MAG_W      = 64,
   parameter int BASE_W     = 16,
   parameter int NUM_WIDTHS = 3,
   localparam int SEL_W = (NUM_WIDTHS > 1) ? $clog2(NUM_WIDTHS) : 1
) (
   input  logic             sign,
   input  logic [MAG_W-1:0] magnitude,
   input  logic [SEL_W-1:0] sel,
   output logic [MAG_W-1:0] result,
   output logic [MAG_W-1:0] indefinite,
   output logic             fits
);

   if ((BASE_W << (NUM_WIDTHS - 1)) != MAG_W) begin : g_bad_widths
      $error("int_range_fit: widest integer must equal MAG_W");
   end

   logic [MAG_W-1:0] res_w   [NUM_WIDTHS];
   logic [MAG_W-1:0] indef_w [NUM_WIDTHS];
   logic             fit_w   [NUM_WIDTHS];
   logic [MAG_W-1:0] negated;

   always_comb negated = ~magnitude + MAG_W'(1);

   for (genvar i = 0; i < NUM_WIDTHS; i++) begin : g_width
      localparam int WI = BASE_W << i;
      localparam logic [MAG_W-1:0] LIM  = {{(MAG_W-1){1'b0}}, 1'b1} << (WI - 1);
      localparam logic [MAG_W-1:0] KEEP = {MAG_W{1'b1}} >> (MAG_W - WI);
      always_comb begin
         indef_w[i] = LIM;
         fit_w[i]   = sign ? (magnitude <= LIM) : (magnitude < LIM);
         res_w[i]   = (sign ? negated : magnitude) & KEEP;
      end
   end

   always_comb begin
      result     = res_w[sel];
      indefinite = indef_w[sel];
      fits       = fit_w[sel];
   end

endmodule

// File: rtl/ext_int_store.sv
module ext_int_store #(
   parameter int EXP_W      = 15,
   parameter int SIG_W      = 64,
   parameter int BASE_W     = 16,
   parameter int NUM_WIDTHS = 3,
   localparam int OP_W  = 1 + EXP_W + SIG_W,
   localparam int SEL_W = (NUM_WIDTHS > 1) ? $clog2(NUM_WIDTHS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [OP_W-1:0] in_operand,
   input  logic [1:0]      in_width,
   input  logic            in_inv_mask,
   output logic            out_valid,
   output logic [SIG_W-1:0] out_data,
   output logic            out_store_en,
   output logic            out_invalid
);
   import ext_int_pkg::*;

   if (NUM_WIDTHS < 1 || NUM_WIDTHS > 4) begin : g_bad_count
      $error("ext_int_store: NUM_WIDTHS must be 1..4");
   end

   logic             op_sign;
   logic [EXP_W-1:0] op_exp;
   logic [SIG_W-1:0] op_sig;
   logic             op_special;
   logic [SIG_W-1:0] mag;
   logic             mag_big;
   logic [SEL_W-1:0] sel;
   logic [SIG_W-1:0] conv;
   logic [SIG_W-1:0] indef;
   logic             fits;
   logic             bad;
   logic [SIG_W-1:0] data_d;
   logic             store_d;
   logic [SEL_W-1:0] sel_q;

   ext_field_split #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_split (
      .operand    (in_operand),
      .sign       (op_sign),
      .exponent   (op_exp),
      .significand(op_sig),
      .special    (op_special)
   );

   ext_mag_shift #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_shift (
      .exponent   (op_exp),
      .significand(op_sig),
      .magnitude  (mag),
      .too_big    (mag_big)
   );

   always_comb sel = SEL_W'(width_index(in_width, NUM_WIDTHS));

   int_range_fit #(.MAG_W(SIG_W), .BASE_W(BASE_W), .NUM_WIDTHS(NUM_WIDTHS)) u_fit (
      .sign      (op_sign),
      .magnitude (mag),
      .sel       (sel),
      .result    (conv),
      .indefinite(indef),
      .fits      (fits)
   );

   always_comb begin
      bad = op_special | mag_big | ~fits;
      if (!bad) begin
         data_d  = conv;
         store_d = 1'b1;
      end else if (in_inv_mask) begin
         data_d  = indef;
         store_d = 1'b1;
      end else begin
         data_d  = '0;
         store_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_data     <= '0;
         out_store_en <= 1'b0;
         out_invalid  <= 1'b0;
         sel_q        <= '0;
      end else begin
         out_valid    <= in_valid;
         out_data     <= in_valid ? data_d : '0;
         out_store_en <= in_valid & store_d;
         out_invalid  <= in_valid & bad;
         sel_q        <= sel;
      end
   end

   // R1: result follows an accepted operand by one cycle
   assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R2: nothing above the selected width
   assert_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_data >> (BASE_W << sel_q)) == '0));
   // R7: masked invalid stores the sign-only pattern
   assert_indef_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_invalid && out_store_en) |->
         (out_data == ({{(SIG_W-1){1'b0}}, 1'b1} << ((BASE_W << sel_q) - 1))));
   // R8: unmasked invalid requests no store and drives zero data
   assert_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_invalid && !out_store_en) |-> (out_data == '0));
   assert_flag_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_invalid || out_store_en) |-> out_valid);

endmodule

// File: tb/ext_int_store_tb.sv
`timescale 1ns/1ps
module ext_int_store_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [79:0] in_operand = '0;
   logic [1:0]  in_width = 2'b00;
   logic        in_inv_mask = 1'b1;
   logic        out_valid;
   logic [63:0] out_data;
   logic        out_store_en;
   logic        out_invalid;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   ext_int_store u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_operand  (in_operand),
      .in_width    (in_width),
      .in_inv_mask (in_inv_mask),
      .out_valid   (out_valid),
      .out_data    (out_data),
      .out_store_en(out_store_en),
      .out_invalid (out_invalid)
   );

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // Normalise a signed integer magnitude into an extended operand.
   function automatic logic [79:0] mk_int(input bit neg, input logic [63:0] m);
      int p;
      p = -1;
      for (int i = 0; i < 64; i++) if (m[i]) p = i;
      if (p < 0) return {neg, 79'd0};
      return {neg, 15'(16383 + p), m << (63 - p)};
   endfunction

   // Present one operand, wait one edge, leave outputs for checking.
   task automatic apply(input logic [79:0] op, input logic [1:0] w, input bit mask);
      @(negedge clk);
      in_operand  = op;
      in_width    = w;
      in_inv_mask = mask;
      in_valid    = 1'b1;
      @(negedge clk);
      in_valid    = 1'b0;
   endtask

   task automatic expect_res(input string req, input logic [63:0] d, input bit inv, input bit st);
      chk({req, " valid"}, 64'(out_valid), 64'd1);
      chk({req, " data"}, out_data, d);
      chk({req, " invalid"}, 64'(out_invalid), 64'(inv));
      chk({req, " store"}, 64'(out_store_en), 64'(st));
   endtask

   task automatic t_reset;
      chk("R1 reset valid", 64'(out_valid), 64'd0);
      chk("R1 reset store", 64'(out_store_en), 64'd0);
      chk("R1 reset invalid", 64'(out_invalid), 64'd0);
   endtask

   task automatic t_latency;
      apply(mk_int(1'b0, 64'd7), 2'b00, 1'b1);
      expect_res("R1 one cycle", 64'd7, 1'b0, 1'b1);
      @(negedge clk);
      chk("R1 drop after one", 64'(out_valid), 64'd0);
   endtask

   task automatic t_truncate;
      apply({1'b0, 15'd16384, 64'hB000_0000_0000_0000}, 2'b01, 1'b1);
      expect_res("R3 +2.75", 64'd2, 1'b0, 1'b1);
      apply({1'b1, 15'd16384, 64'hB000_0000_0000_0000}, 2'b01, 1'b1);
      expect_res("R3 R4 -2.75", 64'h0000_0000_FFFF_FFFE, 1'b0, 1'b1);
   endtask

   task automatic t_signs;
      apply(mk_int(1'b0, 64'd12345), 2'b00, 1'b1);
      expect_res("R2 w16 12345", 64'h3039, 1'b0, 1'b1);
      apply(mk_int(1'b1, 64'd1), 2'b00, 1'b1);
      expect_res("R4 w16 -1", 64'hFFFF, 1'b0, 1'b1);
      apply(mk_int(1'b1, 64'd1), 2'b10, 1'b1);
      expect_res("R4 w64 -1", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
      apply(mk_int(1'b0, 64'd100000), 2'b11, 1'b1);
      expect_res("R2 code11 as 64", 64'd100000, 1'b0, 1'b1);
   endtask

   task automatic t_small;
      apply(80'd0, 2'b01, 1'b1);
      expect_res("R10 zero", 64'd0, 1'b0, 1'b1);
      apply({1'b0, 15'd16382, 64'h8000_0000_0000_0000}, 2'b00, 1'b1);
      expect_res("R10 +0.5", 64'd0, 1'b0, 1'b1);
      apply({1'b1, 15'd16382, 64'hFFFF_0000_0000_0000}, 2'b10, 1'b1);
      expect_res("R10 -0.99", 64'd0, 1'b0, 1'b1);
   endtask

   task automatic t_bounds16;
      apply(mk_int(1'b0, 64'd32767), 2'b00, 1'b1);
      expect_res("R6 w16 max ok", 64'h7FFF, 1'b0, 1'b1);
      apply(mk_int(1'b0, 64'd32768), 2'b00, 1'b1);
      expect_res("R6 R7 w16 +32768", 64'h8000, 1'b1, 1'b1);
      apply(mk_int(1'b1, 64'd32768), 2'b00, 1'b1);
      expect_res("R9 w16 -32768", 64'h8000, 1'b0, 1'b1);
      apply(mk_int(1'b1, 64'd32769), 2'b00, 1'b1);
      expect_res("R6 R7 w16 -32769", 64'h8000, 1'b1, 1'b1);
   endtask

   task automatic t_bounds32;
      apply(mk_int(1'b0, 64'h7FFF_FFFF), 2'b01, 1'b1);
      expect_res("R6 w32 max ok", 64'h7FFF_FFFF, 1'b0, 1'b1);
      apply(mk_int(1'b0, 64'h8000_0000), 2'b01, 1'b0);
      expect_res("R6 R8 w32 +2^31 unmasked", 64'd0, 1'b1, 1'b0);
      apply(mk_int(1'b1, 64'h8000_0000), 2'b01, 1'b0);
      expect_res("R9 w32 -2^31", 64'h8000_0000, 1'b0, 1'b1);
   endtask

   task automatic t_bounds64;
      apply(mk_int(1'b0, 64'h7FFF_FFFF_FFFF_FFFF), 2'b10, 1'b1);
      expect_res("R6 w64 max ok", 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
      apply(mk_int(1'b1, 64'h8000_0000_0000_0000), 2'b10, 1'b1);
      expect_res("R9 w64 -2^63", 64'h8000_0000_0000_0000, 1'b0, 1'b1);
      apply(mk_int(1'b0, 64'h8000_0000_0000_0000), 2'b10, 1'b1);
      expect_res("R6 R7 w64 +2^63", 64'h8000_0000_0000_0000, 1'b1, 1'b1);
      apply({1'b0, 15'd16447, 64'h8000_0000_0000_0000}, 2'b10, 1'b1);
      expect_res("R6 w64 2^64", 64'h8000_0000_0000_0000, 1'b1, 1'b1);
      apply({1'b1, 15'd16500, 64'hC000_0000_0000_0000}, 2'b00, 1'b0);
      expect_res("R6 R8 huge neg w16", 64'd0, 1'b1, 1'b0);
   endtask

   task automatic t_special;
      apply({1'b0, 15'h7FFF, 64'hC000_0000_0000_0000}, 2'b01, 1'b1);
      expect_res("R5 R7 NaN masked", 64'h8000_0000, 1'b1, 1'b1);
      apply({1'b1, 15'h7FFF, 64'h8000_0000_0000_0000}, 2'b10, 1'b0);
      expect_res("R5 R8 -inf unmasked", 64'd0, 1'b1, 1'b0);
      apply({1'b0, 15'h7FFF, 64'h8000_0000_0000_0000}, 2'b00, 1'b1);
      expect_res("R5 R7 +inf w16", 64'h8000, 1'b1, 1'b1);
   endtask

   task automatic t_mask_ignored_when_valid;
      apply(mk_int(1'b0, 64'd5), 2'b00, 1'b0);
      expect_res("R8 mask no effect in range", 64'd5, 1'b0, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latency();
      t_truncate();
      t_signs();
      t_small();
      t_bounds16();
      t_bounds32();
      t_bounds64();
      t_special();
      t_mask_ignored_when_valid();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule